// File: doc/BRIEF.md
# Clip Noise Shaping Saturator

This block sits at the end of a transmit chain, just before a DAC. It takes a signed sample stream that arrives at twice the signal bandwidth rate, after a factor-2 interpolator. Each sample is limited to a symmetric window of plus or minus a programmable level. The amount cut off by each limiting step is the clip error. That error is kept in a short history and fed back through a shaping filter. The filtered value is subtracted from later samples, so the clipping distortion moves up in frequency, above the occupied band.

Two feedback shapes are selectable at run time. The first is a 10-tap FIR filter with signed coefficients that are loaded one tap at a time. The second is a plain one-sample delay with unit weight. Any change of mode starts the shaping from an empty history. There is one register stage from input to output.

Top module: `cns_shaper`

## Requirements
- R1: When `in_valid_i` is high, the result appears on `out_data_o` one clock later, with `out_valid_o` high for exactly that cycle. A cycle with `in_valid_i` low drives `out_valid_o` low in the next cycle and leaves `out_data_o` unchanged.
- R2: Let L be the unsigned 15-bit value on `clip_lvl_i` in the sample's cycle. The output is the pre-clip value forced into the range [-L, +L]. A pre-clip value inside the range passes through unchanged.
- R3: The clip error is the pre-clip value minus the output, saturated to an 18-bit signed range of [-131072, 131071]. Only valid samples store their error, and each stored error becomes history entry e[0] while older entries shift one place toward e[9].
- R4: With `mode_i`=0, the pre-clip value is x - floor((c[0]*e[0] + ... + c[9]*e[9]) / 2^14). Here c[k] are signed 16-bit coefficients, e[0] is the newest error, and the floor rounds toward minus infinity. The sum is formed at full width, with no overflow and no rounding before the final shift.
- R5: With `mode_i`=1, the pre-clip value is x - e[0], where e[0] is the error of the previous valid sample. The coefficients have no effect in this mode.
- R6: Reset clears the error history. The history is also cleared in any cycle where `mode_i` differs from its value in the previous cycle, with the previous value reset to 0. A sample that arrives in such a cycle sees zero feedback, and its own error becomes the only nonzero history entry.
- R7: When `coef_we_i` is high, `coef_data_i` is written to tap `coef_idx_i` at the clock edge. An index of 10 or above changes nothing. A sample in the same cycle as a write still uses the old coefficient. Reset sets all coefficients to zero.
- R8: During reset and directly after it, `out_valid_o` is 0 and `out_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | 16 | Signed input sample |
| clip_lvl_i | input | 15 | Unsigned clip level L |
| mode_i | input | 1 | 0: 10-tap FIR shaping, 1: single-delay shaping |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_idx_i | input | 4 | Coefficient tap index |
| coef_data_i | input | 16 | Signed coefficient value (Q1.14) |
| out_valid_o | output | 1 | Output sample strobe |
| out_data_o | output | 16 | Signed clipped output sample |

## Verification
A mode switch and a sample can fall in the same cycle. So can a coefficient write and a sample. The bench provokes both cases on purpose, with the history already holding nonzero errors and the coefficients already nonzero. It then runs a random phase that toggles the mode and writes taps while valid samples keep flowing. A bench model predicts each output from the stated rules: zero feedback and a single-entry history after a mode flip, and the old tap value for a sample that meets a write. Later samples reveal any history or coefficient left stale, because the model's error history must keep matching the outputs.

// File: rtl/cns_pkg.sv
package cns_pkg;
  typedef enum logic {
    CNS_FIR = 1'b0,
    CNS_DLY = 1'b1
  } cns_mode_e;
endpackage

// File: rtl/cns_coef_bank.sv
module cns_coef_bank #(
  parameter int TAPS = 10,
  parameter int CW   = 16,
  localparam int IW  = $clog2(TAPS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [IW-1:0]             idx_i,
  input  logic [CW-1:0]             data_i,
  output logic [TAPS-1:0][CW-1:0]   coef_o
);
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          coef_o[k] <= '0;
      else if (we_i && idx_i == IW'(k))     coef_o[k] <= data_i;
    end
  end

  AST_IDX_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(idx_i) >= TAPS) |=> $stable(coef_o)); // R7
endmodule

// File: rtl/cns_err_hist.sv
module cns_err_hist #(
  parameter int TAPS = 10,
  parameter int EW   = 18
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      push_i,
  input  logic [EW-1:0]             err_i,
  output logic [TAPS-1:0][EW-1:0]   hist_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_o <= '0;
    end else if (clr_i) begin
      hist_o <= '0;
      if (push_i) hist_o[0] <= err_i;
    end else if (push_i) begin
      for (int k = TAPS - 1; k > 0; k--) hist_o[k] <= hist_o[k-1];
      hist_o[0] <= err_i;
    end
  end

  AST_HIST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !push_i) |=> (hist_o == '0)); // R6
  AST_HIST_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clr_i) |=> (hist_o[1] == $past(hist_o[0]))); // R3
  AST_HIST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !clr_i) |=> $stable(hist_o)); // R3
endmodule

// File: rtl/cns_fir_fb.sv
module cns_fir_fb #(
  parameter int TAPS = 10,
  parameter int EW   = 18,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  localparam int PW  = EW + CW,
  localparam int AW  = PW + $clog2(TAPS)
) (
  input  logic [TAPS-1:0][EW-1:0] hist_i,
  input  logic [TAPS-1:0][CW-1:0] coef_i,
  output logic signed [AW-1:0]    fb_o
);
  logic signed [PW-1:0] prod [TAPS];
  logic signed [AW-1:0] acc;

  for (genvar k = 0; k < TAPS; k++) begin : g_mul
    assign prod[k] = PW'($signed(hist_i[k])) * PW'($signed(coef_i[k]));
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) acc = acc + AW'(prod[k]);
  end

  assign fb_o = acc >>> FRAC;
endmodule

// File: rtl/cns_clip.sv
module cns_clip #(
  parameter int DW = 16,
  parameter int EW = 18,
  parameter int VW = 40
) (
  input  logic signed [VW-1:0] v_i,
  input  logic [DW-2:0]        lvl_i,
  output logic [DW-1:0]        y_o,
  output logic [EW-1:0]        err_o
);
  logic signed [VW-1:0] pos, neg, e_v, y_v;
  localparam logic signed [VW-1:0] EMAX = VW'((64'sd1 <<< (EW - 1)) - 1);
  localparam logic signed [VW-1:0] EMIN = -EMAX - VW'(1);

  assign pos = VW'({1'b0, lvl_i});
  assign neg = -pos;

  always_comb begin
    if (v_i > pos)      y_o = {1'b0, lvl_i};
    else if (v_i < neg) y_o = -{1'b0, lvl_i};
    else                y_o = v_i[DW-1:0];
  end

  assign y_v = VW'($signed(y_o));
  assign e_v = v_i - y_v;

  always_comb begin
    if (e_v > EMAX)      err_o = {1'b0, {(EW-1){1'b1}}};
    else if (e_v < EMIN) err_o = {1'b1, {(EW-1){1'b0}}};
    else                 err_o = e_v[EW-1:0];
  end
endmodule

// File: rtl/cns_shaper.sv
module cns_shaper
  import cns_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int TAPS = 10,
  parameter int FRAC = 14,
  parameter int EW   = DW + 2,
  localparam int IW  = $clog2(TAPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic [DW-2:0] clip_lvl_i,
  input  logic          mode_i,
  input  logic          coef_we_i,
  input  logic [IW-1:0] coef_idx_i,
  input  logic [CW-1:0] coef_data_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o
);
  localparam int AW = EW + CW + $clog2(TAPS);
  localparam int VW = AW + 1;

  logic [TAPS-1:0][CW-1:0] coef;
  logic [TAPS-1:0][EW-1:0] hist;
  logic signed [AW-1:0]    fb_fir, fb;
  logic signed [VW-1:0]    v;
  logic [DW-1:0]           y;
  logic [EW-1:0]           err;
  cns_mode_e               mode_q, mode_n;
  logic                    mode_chg;

  assign mode_n   = cns_mode_e'(mode_i);
  assign mode_chg = (mode_n != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= CNS_FIR;
    else         mode_q <= mode_n;
  end

  cns_coef_bank #(.TAPS(TAPS), .CW(CW)) u_coef (
    .clk_i, .rst_ni,
    .we_i  (coef_we_i),
    .idx_i (coef_idx_i),
    .data_i(coef_data_i),
    .coef_o(coef)
  );

  cns_err_hist #(.TAPS(TAPS), .EW(EW)) u_hist (
    .clk_i, .rst_ni,
    .clr_i (mode_chg),
    .push_i(in_valid_i),
    .err_i (err),
    .hist_o(hist)
  );

  cns_fir_fb #(.TAPS(TAPS), .EW(EW), .CW(CW), .FRAC(FRAC)) u_fir (
    .hist_i(hist),
    .coef_i(coef),
    .fb_o  (fb_fir)
  );

  // history is being flushed on a mode change: feedback is empty
  always_comb begin
    if (mode_chg)              fb = '0;
    else if (mode_n == CNS_DLY) fb = AW'($signed(hist[0]));
    else                       fb = fb_fir;
  end

  assign v = VW'($signed(in_data_i)) - VW'(fb);

  cns_clip #(.DW(DW), .EW(EW), .VW(VW)) u_clip (
    .v_i  (v),
    .lvl_i(clip_lvl_i),
    .y_o  (y),
    .err_o(err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_data_o <= y;
    end
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && $stable(out_data_o))); // R1
  AST_CLIP_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> ($signed(out_data_o) <= $signed({1'b0, $past(clip_lvl_i)}))); // R2
  AST_CLIP_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> ($signed(out_data_o) >= -$signed({1'b0, $past(clip_lvl_i)}))); // R2
  AST_ERR_INSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && $signed(out_data_o) < $signed({1'b0, $past(clip_lvl_i)})
                 && $signed(out_data_o) > -$signed({1'b0, $past(clip_lvl_i)}))
    |-> (hist[0] == '0)); // R3
  AST_MODE_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> (hist[TAPS-1:1] == '0)); // R6
endmodule

// File: tb/cns_shaper_test.sv
`timescale 1ns/1ps
module cns_shaper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic [14:0] clip_lvl = '0;
  logic        mode = 1'b0;
  logic        coef_we = 1'b0;
  logic [3:0]  coef_idx = '0;
  logic [15:0] coef_data = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int checks = 0, errors = 0;
  bit done = 0;

  longint hist_m [10];
  longint coef_m [10];
  int     mode_prev;
  logic   exp_valid;
  longint exp_out;
  bit     armed;
  string  exp_tag;

  always #2 clk = ~clk;

  cns_shaper uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .clip_lvl_i(clip_lvl), .mode_i(mode), .coef_we_i(coef_we),
    .coef_idx_i(coef_idx), .coef_data_i(coef_data),
    .out_valid_o(out_valid), .out_data_o(out_data)
  );

  function automatic longint sat_err(longint e);
    if (e > 131071)  return 131071;
    if (e < -131072) return -131072;
    return e;
  endfunction

  function automatic longint clamp(longint v, longint l);
    if (v > l)  return l;
    if (v < -l) return -l;
    return v;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 10; k++) begin hist_m[k] = 0; coef_m[k] = 0; end
    mode_prev = 0; exp_valid = 0; exp_out = 0; armed = 0;
  endtask

  task automatic check_out();
    checks++;
    if (out_valid !== exp_valid || $signed(out_data) != exp_out) begin
      errors++;
      $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d",
               exp_tag, out_valid, $signed(out_data), exp_valid, exp_out);
    end
  endtask

  // called at a negedge: check previous cycle, drive new inputs, predict
  task automatic tick(input bit v, input longint x, input int l, input bit m,
                      input bit we, input int idx, input longint cd);
    longint fb, pre, y;
    bit chg;
    if (armed) check_out();
    in_valid = v; in_data = 16'(x); clip_lvl = 15'(l); mode = m;
    coef_we = we; coef_idx = 4'(idx); coef_data = 16'(cd);
    chg = (int'(m) != mode_prev);
    mode_prev = int'(m);
    if (chg) for (int k = 0; k < 10; k++) hist_m[k] = 0;
    exp_tag = v ? (m ? "R5 R2 R3" : "R4 R2 R3") : "R1";
    if (chg) exp_tag = "R6";
    if (we && v) exp_tag = "R7";
    if (v) begin
      if (chg) fb = 0;
      else if (m) fb = hist_m[0];
      else begin
        fb = 0;
        for (int k = 0; k < 10; k++) fb += hist_m[k] * coef_m[k];
        fb = fb >>> 14;
      end
      pre = x - fb;
      y = clamp(pre, l);
      for (int k = 9; k > 0; k--) hist_m[k] = hist_m[k-1];
      hist_m[0] = sat_err(pre - y);
      exp_out = y;
    end
    exp_valid = v;
    if (we && idx < 10) coef_m[idx] = cd;
    armed = 1;
    @(negedge clk);
  endtask

  function automatic longint rnd_s16();
    return longint'($signed(16'($urandom)));
  endfunction

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R8: outputs idle during reset
    checks++;
    if (out_valid !== 1'b0 || out_data !== 16'd0) begin
      errors++; $display("FAIL R8: valid=%0b data=%0d expected valid=0 data=0", out_valid, out_data);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 16'd0) begin
      errors++; $display("FAIL R8: valid=%0b data=%0d expected valid=0 data=0", out_valid, out_data);
    end

    // R2: pass-through and clipping with zero coefficients
    tick(1, 1000, 2000, 0, 0, 0, 0);
    tick(1, 30000, 2000, 0, 0, 0, 0);
    tick(1, -30000, 2000, 0, 0, 0, 0);
    tick(1, 12345, 0, 0, 0, 0, 0);
    tick(0, 777, 100, 0, 0, 0, 0);     // R1 hold
    tick(0, 0, 100, 0, 0, 0, 0);

    // R5: single delay feedback, big overdrive
    tick(1, 20000, 5000, 1, 0, 0, 0);
    tick(1, 20000, 5000, 1, 0, 0, 0);
    tick(1, -32768, 5000, 1, 0, 0, 0);
    tick(1, 100, 5000, 1, 0, 0, 0);

    // R7: load taps, out-of-range index write, write during sample
    tick(0, 0, 5000, 0, 1, 0, 16384);
    tick(0, 0, 5000, 0, 1, 1, -8192);
    tick(0, 0, 5000, 0, 1, 2, 4096);
    tick(0, 0, 5000, 0, 1, 12, 32767);
    tick(0, 0, 5000, 0, 1, 10, -32768);
    for (int i = 0; i < 12; i++) tick(1, 25000, 3000, 0, 0, 0, 0);   // R4
    tick(1, -25000, 3000, 0, 1, 0, -16384);                           // R7 same cycle
    tick(1, -25000, 3000, 0, 0, 0, 0);
    tick(1, 32767, 3000, 0, 1, 15, 9999);
    tick(1, 32767, 3000, 0, 0, 0, 0);

    // R6: mode flip together with a sample, history nonzero
    tick(1, 30000, 1000, 1, 0, 0, 0);
    tick(1, 30000, 1000, 1, 0, 0, 0);
    tick(1, -30000, 1000, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) tick(1, -30000, 1000, 0, 0, 0, 0);
    tick(0, 0, 1000, 1, 0, 0, 0);                                      // idle flip
    tick(1, 9000, 1000, 1, 0, 0, 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      bit v, m, we;
      int l, idx;
      v  = ($urandom % 4) != 0;
      m  = (($urandom % 40) == 0) ? ~mode : mode;
      we = ($urandom % 10) == 0;
      idx = $urandom % 16;
      l  = (($urandom % 8) == 0) ? int'($urandom % 64) : int'($urandom % 32768);
      tick(v, rnd_s16(), l, m, we, idx, longint'($signed(16'($urandom % 16384) - 16'd8192)));
    end
    tick(0, 0, 0, mode, 0, 0, 0);
    check_out();

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule